// File: doc/BRIEF.md
# DisplayPort Link Configuration Selector

This block picks the lane count and link rate for a display mode. It works from the mode's pixel clock, the colour depth and what the sink reports: its capability byte for lane count, its maximum rate code, and whether it supports revision 1.2 signalling. A `start` pulse captures all inputs. A small state machine then steps through candidate configurations, one per clock. The block raises `done_o` for a single cycle once the result is on the outputs.

The search works in two phases. In the first, the sink's maximum rate is held fixed and the lane count grows through the powers of two until the link can carry the mode. In the second, that lane count is held and the rates are tried from the slowest up. The fastest rate is tried only for revision 1.2 sinks. No division is needed: each fit test compares `pixel_clock × bpp` against `rate × lanes × 8`. A mode that would need the fastest rate on a sink without 1.2 support is flagged as too fast.

States and transitions:
- `ST_IDLE` goes to `ST_LANE_SCAN` on `start_i`. This is the capture transition.
- `ST_LANE_SCAN` loops to itself while the trial lane count is below the sink maximum and does not fit (the doubling transition). Otherwise it goes to `ST_RATE_SCAN`, which is the lane-settle transition.
- `ST_RATE_SCAN` loops to itself while the trial rate neither fits nor is the last allowed rate (the rate-step transition). Otherwise it goes to `ST_REPORT`, which is the finalize transition.
- `ST_REPORT` always goes to `ST_IDLE`. This is the release transition.

Top module: `dp_link_cfg_sel`

## Requirements
- R1: After reset, `done_o`=0, `lanes_o`=0, `rate_code_o`=8'h00 and `too_fast_o`=0.
- R2: Bits per pixel is 3 × `bpc_i`. A `bpc_i` of 0 means the depth is unknown, and 24 bits per pixel is used.
- R3: The sink's maximum lane count is bits [4:0] of `lane_cap_i`; the upper bits are ignored. Rate codes decode as 8'h06 = 162000, 8'h0A = 270000 and 8'h14 = 540000. Any other code is treated as 162000.
- R4: Trial lane counts are 1, 2, 4 and so on, for as long as they stay strictly below the sink maximum. The first count that fits at the sink's maximum rate is chosen. If none fits, the sink maximum is chosen. A configuration fits when `pix_clk_i × bpp ≤ rate × lanes × 8`.
- R5: For the chosen lane count, 162000 is tried first, then 270000, then 540000. The first rate that fits is reported as its code.
- R6: 540000 is tried only when `v12_i`=1. If no tried rate fits, the sink's maximum rate is reported.
- R7: `too_fast_o`=1 exactly when the reported rate is 540000 and `v12_i` was 0.
- R8: `done_o` is high for exactly one cycle per search. The result outputs hold their values until the next search ends.
- R9: `start_i` is ignored while a search is in progress. The result belongs to the inputs captured at the accepted start, and only one `done_o` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search; all other inputs are captured on this cycle |
| pix_clk_i | input | PIX_W | Mode pixel clock, in the same units as the rate values |
| bpc_i | input | BPC_W | Bits per colour component, 0 = unknown |
| lane_cap_i | input | CAP_W | Sink lane capability byte; the maximum lane count is in the low bits |
| rate_cap_i | input | 8 | Sink maximum rate code |
| v12_i | input | 1 | Sink supports revision 1.2 signalling |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| lanes_o | output | LANE_W | Selected lane count |
| rate_code_o | output | 8 | Selected rate code |
| too_fast_o | output | 1 | Mode needs the fastest rate on a sink without 1.2 support |

## Verification
A corrupted trial lane count or rate index shows up as a wrong `lanes_o` or `rate_code_o` on the next `done_o` pulse. That pulse comes at most a few cycles after start, because each state advances once per clock. A state register stuck outside `ST_IDLE` shows up either as no `done_o` at all or as repeated pulses. Captured inputs that are overwritten mid-search show up as a result that matches the second, ignored start rather than the first. The cases cover fits in the lane phase, fits in the rate phase, both fallback paths, unknown depth, unknown rate code and masked capability bits, so each transition is taken at least once.

// File: rtl/dp_link_cfg_pkg.sv
package dp_link_cfg_pkg;

    localparam int RATE_W = 20;

    typedef enum logic [1:0] {
        RIDX_162 = 2'd0,
        RIDX_270 = 2'd1,
        RIDX_540 = 2'd2
    } rate_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LANE_SCAN = 2'd1,
        ST_RATE_SCAN = 2'd2,
        ST_REPORT    = 2'd3
    } sel_state_t;

    localparam logic [7:0] CODE_162 = 8'h06;
    localparam logic [7:0] CODE_270 = 8'h0A;
    localparam logic [7:0] CODE_540 = 8'h14;

    function automatic logic [7:0] idx_to_code(input rate_idx_t idx);
        case (idx)
            RIDX_270: return CODE_270;
            RIDX_540: return CODE_540;
            default:  return CODE_162;
        endcase
    endfunction

endpackage

// File: rtl/dp_link_rate_map.sv
module dp_link_rate_map
    import dp_link_cfg_pkg::*;
#(
    parameter int KHZ_W = RATE_W
) (
    input  logic [7:0]       cap_code_i,
    input  rate_idx_t        try_idx_i,
    output rate_idx_t        cap_idx_o,
    output logic [KHZ_W-1:0] try_khz_o
);

    // Sink rate code to index; unknown codes fall back to the slowest rate (R3)
    always_comb begin
        unique case (cap_code_i)
            CODE_270: cap_idx_o = RIDX_270;
            CODE_540: cap_idx_o = RIDX_540;
            default:  cap_idx_o = RIDX_162;
        endcase
    end

    always_comb begin
        unique case (try_idx_i)
            RIDX_270: try_khz_o = KHZ_W'(270000);
            RIDX_540: try_khz_o = KHZ_W'(540000);
            default:  try_khz_o = KHZ_W'(162000);
        endcase
    end

endmodule

// File: rtl/dp_link_fit_cmp.sv
module dp_link_fit_cmp #(
    parameter int PIX_W  = 20,
    parameter int BPP_W  = 6,
    parameter int LANE_W = 6,
    parameter int KHZ_W  = 20
) (
    input  logic [PIX_W-1:0]  pix_i,
    input  logic [BPP_W-1:0]  bpp_i,
    input  logic [LANE_W-1:0] lanes_i,
    input  logic [KHZ_W-1:0]  khz_i,
    output logic              fits_o
);

    localparam int DEM_W  = PIX_W + BPP_W;
    localparam int SUP_W  = KHZ_W + LANE_W + 3;
    localparam int PROD_W = (DEM_W > SUP_W) ? DEM_W : SUP_W;

    logic [PROD_W-1:0] demand;
    logic [PROD_W-1:0] supply;

    // Cross-multiplied form of pix <= rate*lanes*8/bpp
    assign demand = PROD_W'(pix_i) * PROD_W'(bpp_i);
    assign supply = (PROD_W'(khz_i) * PROD_W'(lanes_i)) << 3;
    assign fits_o = (demand <= supply);

endmodule

// File: rtl/dp_link_cfg_sel.sv
module dp_link_cfg_sel
    import dp_link_cfg_pkg::*;
#(
    parameter int PIX_W  = 20,
    parameter int BPC_W  = 4,
    parameter int LANE_W = 5,
    parameter int CAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PIX_W-1:0]  pix_clk_i,
    input  logic [BPC_W-1:0]  bpc_i,
    input  logic [CAP_W-1:0]  lane_cap_i,
    input  logic [7:0]        rate_cap_i,
    input  logic              v12_i,
    output logic              done_o,
    output logic [LANE_W-1:0] lanes_o,
    output logic [7:0]        rate_code_o,
    output logic              too_fast_o
);

    localparam int BPP_W   = BPC_W + 2;
    localparam int TRIAL_W = LANE_W + 1;

    sel_state_t state_q, state_d;

    logic [PIX_W-1:0]   pix_q;
    logic [BPP_W-1:0]   bpp_q;
    logic [LANE_W-1:0]  max_lanes_q;
    rate_idx_t          cap_idx_q;
    logic               v12_q;
    logic [TRIAL_W-1:0] lane_q;
    logic [LANE_W-1:0]  sel_lanes_q;
    rate_idx_t          rate_q;
    logic [LANE_W-1:0]  res_lanes_q;
    logic [7:0]         res_code_q;
    logic               res_tf_q;

    rate_idx_t          cap_idx_dec;
    rate_idx_t          cmp_idx;
    logic [RATE_W-1:0]  cmp_khz;
    logic [TRIAL_W-1:0] cmp_lanes;
    logic               fits;
    logic               lane_below;
    logic               rate_last;
    rate_idx_t          final_idx;
    logic [BPP_W-1:0]   bpp_d;

    dp_link_rate_map #(.KHZ_W(RATE_W)) i_rate_map (
        .cap_code_i (rate_cap_i),
        .try_idx_i  (cmp_idx),
        .cap_idx_o  (cap_idx_dec),
        .try_khz_o  (cmp_khz)
    );

    dp_link_fit_cmp #(
        .PIX_W  (PIX_W),
        .BPP_W  (BPP_W),
        .LANE_W (TRIAL_W),
        .KHZ_W  (RATE_W)
    ) i_fit_cmp (
        .pix_i   (pix_q),
        .bpp_i   (bpp_q),
        .lanes_i (cmp_lanes),
        .khz_i   (cmp_khz),
        .fits_o  (fits)
    );

    // Lane phase tests at the sink maximum rate; rate phase at the trial rate
    assign cmp_lanes  = (state_q == ST_RATE_SCAN) ? TRIAL_W'(sel_lanes_q) : lane_q;
    assign cmp_idx    = (state_q == ST_RATE_SCAN) ? rate_q : cap_idx_q;
    assign lane_below = (lane_q < TRIAL_W'(max_lanes_q));
    assign rate_last  = (rate_q == RIDX_540) || ((rate_q == RIDX_270) && !v12_q);
    assign final_idx  = fits ? rate_q : cap_idx_q;
    assign bpp_d      = (bpc_i == '0) ? BPP_W'(24) : BPP_W'(BPP_W'(bpc_i) * BPP_W'(3));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_LANE_SCAN;
            ST_LANE_SCAN: if (!lane_below || fits) state_d = ST_RATE_SCAN;
            ST_RATE_SCAN: if (fits || rate_last) state_d = ST_REPORT;
            ST_REPORT:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q       <= '0;
            bpp_q       <= '0;
            max_lanes_q <= '0;
            cap_idx_q   <= RIDX_162;
            v12_q       <= 1'b0;
            lane_q      <= '0;
            sel_lanes_q <= '0;
            rate_q      <= RIDX_162;
            res_lanes_q <= '0;
            res_code_q  <= 8'h00;
            res_tf_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    pix_q       <= pix_clk_i;
                    bpp_q       <= bpp_d;
                    max_lanes_q <= lane_cap_i[LANE_W-1:0];
                    cap_idx_q   <= cap_idx_dec;
                    v12_q       <= v12_i;
                    lane_q      <= TRIAL_W'(1);
                end
                ST_LANE_SCAN: begin
                    if (lane_below && !fits) begin
                        lane_q <= lane_q << 1;
                    end else begin
                        sel_lanes_q <= lane_below ? LANE_W'(lane_q) : max_lanes_q;
                        rate_q      <= RIDX_162;
                    end
                end
                ST_RATE_SCAN: begin
                    if (fits || rate_last) begin
                        res_lanes_q <= sel_lanes_q;
                        res_code_q  <= idx_to_code(final_idx);
                        res_tf_q    <= (final_idx == RIDX_540) && !v12_q;
                    end else begin
                        rate_q <= (rate_q == RIDX_162) ? RIDX_270 : RIDX_540;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done_o      = (state_q == ST_REPORT);
        lanes_o     = res_lanes_q;
        rate_code_o = res_code_q;
        too_fast_o  = res_tf_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_LANES_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lanes_o <= max_lanes_q)); // R4

    AST_TOP_RATE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !v12_q && (cap_idx_q != RIDX_540)) |-> (rate_code_o != CODE_540)); // R6

    AST_TOO_FAST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (too_fast_o == ((rate_code_o == CODE_540) && !v12_q))); // R7

    AST_ONE_TRIAL_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LANE_SCAN) |-> $onehot(lane_q)); // R4

    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(pix_q) && $stable(v12_q))); // R9

endmodule

// File: tb/test_dp_link_cfg_sel.sv
module test_dp_link_cfg_sel;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [19:0] pix_clk_i = '0;
    logic [3:0]  bpc_i = '0;
    logic [7:0]  lane_cap_i = '0;
    logic [7:0]  rate_cap_i = '0;
    logic        v12_i = 1'b0;
    logic        done_o;
    logic [4:0]  lanes_o;
    logic [7:0]  rate_code_o;
    logic        too_fast_o;

    int checks = 0;
    int failures = 0;
    int tx_cnt = 0;
    int rx_cnt = 0;
    int cyc = 0;

    int    q_lanes[$];
    int    q_code[$];
    bit    q_tf[$];
    string q_tag[$];

    dp_link_cfg_sel i_dp_link_cfg_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pix_clk_i   (pix_clk_i),
        .bpc_i       (bpc_i),
        .lane_cap_i  (lane_cap_i),
        .rate_cap_i  (rate_cap_i),
        .v12_i       (v12_i),
        .done_o      (done_o),
        .lanes_o     (lanes_o),
        .rate_code_o (rate_code_o),
        .too_fast_o  (too_fast_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements
    function automatic void ref_cfg(input longint pix, input int bpc, input int cap, input int code,
                                    input bit v12, output int lanes, output int rcode, output bit tf);
        longint bpp, maxl, maxr, rate;
        longint tries[3];
        int ntry;
        bpp  = (bpc == 0) ? 24 : bpc * 3;                  // R2
        maxl = cap & 31;                                   // R3
        maxr = (code == 8'h0A) ? 270000 : (code == 8'h14) ? 540000 : 162000;
        lanes = int'(maxl);                                // R4
        for (longint l = 1; l < maxl; l = l * 2) begin
            if (pix <= (maxr * l * 8) / bpp) begin
                lanes = int'(l);
                break;
            end
        end
        tries[0] = 162000; tries[1] = 270000; tries[2] = 540000;
        ntry = v12 ? 3 : 2;                                // R6
        rate = maxr;
        for (int k = 0; k < ntry; k++) begin               // R5
            if (pix <= (tries[k] * lanes * 8) / bpp) begin
                rate = tries[k];
                break;
            end
        end
        rcode = (rate == 162000) ? 8'h06 : (rate == 270000) ? 8'h0A : 8'h14;
        tf = (rate == 540000) && !v12;                     // R7
    endfunction

    // Driver: push expectation, issue start, wait for the monitor
    task automatic run_case(input string tag, input int pix, input int bpc, input int cap,
                            input int code, input bit v12, input bit poke);
        int el, ec;
        bit et;
        ref_cfg(pix, bpc, cap, code, v12, el, ec, et);
        q_lanes.push_back(el); q_code.push_back(ec); q_tf.push_back(et); q_tag.push_back(tag);
        tx_cnt++;
        @(negedge clk);
        pix_clk_i = 20'(pix); bpc_i = 4'(bpc); lane_cap_i = 8'(cap);
        rate_cap_i = 8'(code); v12_i = v12; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R9: second start while busy, with very different inputs
            pix_clk_i = 20'd1000; lane_cap_i = 8'd1; v12_i = ~v12; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        do @(negedge clk); while (rx_cnt != tx_cnt);
        repeat (3) @(negedge clk);
        // R8: results hold after the pulse, no further pulse
        check("R8", "held lanes", lanes_o, el);
        check("R8", "held rate code", rate_code_o, ec);
        check("R8", "held too_fast", too_fast_o, et);
        if (poke) check("R9", "done pulses", rx_cnt, tx_cnt);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            rx_cnt++;
            if (q_tag.size() == 0) begin
                check("R8", "unexpected done", 1, 0);
            end else begin
                int el, ec;
                bit et;
                string tg;
                el = q_lanes.pop_front(); ec = q_code.pop_front();
                et = q_tf.pop_front(); tg = q_tag.pop_front();
                check(tg, "lanes", lanes_o, el);
                check(tg, "rate code", rate_code_o, ec);
                check(tg, "too_fast", too_fast_o, et);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset done", done_o, 0);
        check("R1", "reset lanes", lanes_o, 0);
        check("R1", "reset rate code", rate_code_o, 0);
        check("R1", "reset too_fast", too_fast_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case("R4 R5 one lane slow", 25000, 8, 8'h04, 8'h0A, 1'b0, 1'b0);
        run_case("R4 R5 two lanes mid", 148500, 8, 8'h04, 8'h0A, 1'b0, 1'b0);
        run_case("R6 top rate allowed", 300000, 8, 8'h04, 8'h14, 1'b1, 1'b0);
        run_case("R6 R7 top rate fallback", 300000, 8, 8'h04, 8'h14, 1'b0, 1'b0);
        run_case("R4 R6 max lanes fallback", 600000, 8, 8'h04, 8'h0A, 1'b0, 1'b0);
        run_case("R2 unknown depth", 148500, 0, 8'h04, 8'h0A, 1'b0, 1'b0);
        run_case("R2 ten bit depth", 100000, 10, 8'h02, 8'h0A, 1'b0, 1'b0);
        run_case("R3 masked cap bits", 25000, 8, 8'h81, 8'h0A, 1'b0, 1'b0);
        run_case("R3 unknown rate code", 200000, 8, 8'h04, 8'h00, 1'b0, 1'b0);
        run_case("R4 R5 eight lane sink", 600000, 8, 8'h08, 8'h14, 1'b1, 1'b0);
        run_case("R9 busy start ignored", 148500, 8, 8'h04, 8'h0A, 1'b0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule